// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a plain 32-bit register bus. A down-counter is loaded from a programmable reload register only when software writes a fixed 16-bit key into a dedicated restart register. While enabled, the counter steps down once per count step. A count step is either every clock cycle or each pulse of an external 1 MHz tick enable, and a configuration bit chooses between the two.

When the count reaches zero, the block produces a single-cycle expiry event. That event drives whichever actions the configuration selects: a reset request tagged with a reset domain, an external signal request, and a request to boot from an alternate image. After expiry the counter stays at zero until the key is written again.

A sticky expiry flag backs a level interrupt, and software clears the flag by writing 1 to it. A second sticky flag records that an alternate-image boot was requested. That flag is cleared only by reset.

Top module: `wdt_core`

## Requirements
- R1: After reset the count reads RELOAD_RST, the configuration register reads 0, the status register reads 0, and all request outputs and the interrupt are low.
- R2: Register offsets are: count (read-only) at 0x00, reload value (read/write) at 0x04, restart key at 0x08 (reads 0), configuration (bits 7:0 read/write) at 0x0C, and status at 0x10.
- R3: Writing exactly 0x00004755 to 0x08 loads the counter from the reload register and re-arms it after an expiry. Any other written value, including one with nonzero upper bits, leaves the count unchanged.
- R4: With configuration bit 0 (run) set, the counter decrements by one per step. When bit 4 is 0, a step is every clock cycle. When bit 4 is 1, a step happens only on cycles where tick_1us is high.
- R5: After a load with value N ≥ 1, expiry occurs on the Nth step; a load of 0 expires on the first step. Expiry asserts wdt_rst_req (if bit 1 is set), wdt_ext_req (if bit 3) and wdt_alt_boot_req (if bit 7) for exactly one cycle. The count then holds at 0 with no further expiry until the next key write.
- R6: Clearing bit 0 freezes the count and leaves the reload value unchanged. Setting bit 0 again resumes counting from the frozen value.
- R7: wdt_rst_scope always equals configuration bits 6:5, encoded as 00 = SoC, 01 = full chip, 10 = CPU only.
- R8: Status bit 0 is set on expiry and stays set until software writes 1 to status bit 0.
- R9: Status bit 1 is set on expiry when configuration bit 7 is set. Writes cannot clear it; only reset does.
- R10: wdt_irq is a level that is high exactly while status bit 0 and configuration bit 2 are both set.
- R11: A key write in a cycle that is also a count step loads the reload value; the step is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | 1 MHz count enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| wdt_irq | output | 1 | Expiry interrupt level |
| wdt_rst_req | output | 1 | One-cycle reset request on expiry |
| wdt_rst_scope | output | 2 | Selected reset domain |
| wdt_ext_req | output | 1 | One-cycle external signal request on expiry |
| wdt_alt_boot_req | output | 1 | One-cycle alternate-image boot request on expiry |

## Verification
The bench instantiates the block with RELOAD_RST set to 40 and HAS_FAST_CLK at 1, and keeps the 32-bit counter. Because the fast clock option is present, per-cycle stepping is available, so every expiry scenario plays out in a few dozen cycles and the exact cycle of expiry can be compared with the loaded value. The tick-gated mode is exercised with hand-placed tick pulses, which shows that the count moves only when a tick arrives.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int unsigned OFS_COUNT  = 'h00;
   localparam int unsigned OFS_RELOAD = 'h04;
   localparam int unsigned OFS_KICK   = 'h08;
   localparam int unsigned OFS_CFG    = 'h0C;
   localparam int unsigned OFS_STAT   = 'h10;

   localparam int unsigned CFG_W = 8;

   typedef enum logic [1:0] {
      SCOPE_SOC  = 2'b00,
      SCOPE_CHIP = 2'b01,
      SCOPE_CPU  = 2'b10,
      SCOPE_RSVD = 2'b11
   } scope_e;

   // packed MSB first: bit7 alt boot, 6:5 scope, 4 tick select, 3 ext, 2 irq, 1 reset, 0 run
   typedef struct packed {
      logic   alt_boot;
      scope_e scope;
      logic   use_tick;
      logic   ext_on;
      logic   irq_on;
      logic   rst_on;
      logic   run;
   } cfg_t;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 5,
   parameter int unsigned CNT_W        = 32,
   parameter int unsigned KEY_W        = 16,
   parameter logic [KEY_W-1:0] KEY     = 16'h4755,
   parameter bit          HAS_FAST_CLK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic [1:0]        stat_val,
   output cfg_t              cfg,
   output logic [CNT_W-1:0]  reload_q,
   output logic              kick,
   output logic              stat_clr,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(KEY);

   logic sel_reload, sel_kick, sel_cfg, sel_stat, sel_count;
   cfg_t cfg_q;

   assign sel_count  = (bus_addr == ADDR_W'(OFS_COUNT));
   assign sel_reload = (bus_addr == ADDR_W'(OFS_RELOAD));
   assign sel_kick   = (bus_addr == ADDR_W'(OFS_KICK));
   assign sel_cfg    = (bus_addr == ADDR_W'(OFS_CFG));
   assign sel_stat   = (bus_addr == ADDR_W'(OFS_STAT));

   assign kick     = bus_we && sel_kick && (bus_wdata == KEY_WORD);
   assign stat_clr = bus_we && sel_stat && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (bus_we && sel_cfg) begin
         cfg_q <= cfg_t'(bus_wdata[CFG_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
      end else if (bus_we && sel_reload) begin
         reload_q <= bus_wdata[CNT_W-1:0];
      end
   end

   generate
      if (HAS_FAST_CLK) begin : g_sel_clk
         assign cfg = cfg_q;
      end else begin : g_tick_only
         always_comb begin
            cfg          = cfg_q;
            cfg.use_tick = 1'b1;
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (sel_count)       bus_rdata = DATA_W'(cnt_val);
      else if (sel_reload) bus_rdata = DATA_W'(reload_q);
      else if (sel_cfg)    bus_rdata = DATA_W'(cfg);
      else if (sel_stat)   bus_rdata = DATA_W'(stat_val);
   end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned      CNT_W      = 32,
   parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic             kick,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt_q,
   output logic             fire_q
);

   logic halted_q;
   logic advance;

   assign advance = run && step && !halted_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= RELOAD_RST;
         halted_q <= 1'b0;
         fire_q   <= 1'b0;
      end else begin
         fire_q <= 1'b0;
         if (kick) begin
            cnt_q    <= reload;
            halted_q <= 1'b0;
         end else if (advance) begin
            if (cnt_q <= CNT_W'(1)) begin
               cnt_q    <= '0;
               halted_q <= 1'b1;
               fire_q   <= 1'b1;
            end else begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fire,
   input  logic       rst_on,
   input  logic       irq_on,
   input  logic       ext_on,
   input  logic       boot_on,
   input  logic       stat_clr,
   output logic       rst_req,
   output logic       ext_req,
   output logic       boot_req,
   output logic       irq,
   output logic [1:0] stat_q
);

   logic exp_q, boot_seen_q;

   assign rst_req  = fire && rst_on;
   assign ext_req  = fire && ext_on;
   assign boot_req = fire && boot_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q       <= 1'b0;
         boot_seen_q <= 1'b0;
      end else begin
         if (fire)          exp_q <= 1'b1;
         else if (stat_clr) exp_q <= 1'b0;
         if (boot_req)      boot_seen_q <= 1'b1;
      end
   end

   assign irq    = exp_q && irq_on;
   assign stat_q = {boot_seen_q, exp_q};

endmodule

// File: rtl/wdt_core.sv
module wdt_core
   import wdt_pkg::*;
#(
   parameter int unsigned      DATA_W       = 32,
   parameter int unsigned      ADDR_W       = 5,
   parameter int unsigned      CNT_W        = 32,
   parameter int unsigned      KEY_W        = 16,
   parameter logic [KEY_W-1:0] KEY          = 16'h4755,
   parameter logic [CNT_W-1:0] RELOAD_RST   = '1,
   parameter bit               HAS_FAST_CLK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1us,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdt_irq,
   output logic              wdt_rst_req,
   output logic [1:0]        wdt_rst_scope,
   output logic              wdt_ext_req,
   output logic              wdt_alt_boot_req
);

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("wdt_core: CNT_W must lie in 2..DATA_W");
      end
      if (KEY_W > DATA_W) begin : g_bad_key
         $error("wdt_core: KEY_W exceeds DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("wdt_core: ADDR_W too small for the register map");
      end
      if (DATA_W < CFG_W) begin : g_bad_data
         $error("wdt_core: DATA_W narrower than configuration");
      end
   endgenerate

   cfg_t             cfg;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] cnt;
   logic             kick, stat_clr, fire, step;
   logic [1:0]       stat;

   wdt_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
      .KEY_W(KEY_W), .KEY(KEY), .HAS_FAST_CLK(HAS_FAST_CLK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .cnt_val(cnt), .stat_val(stat), .cfg(cfg),
      .reload_q(reload), .kick(kick), .stat_clr(stat_clr), .bus_rdata(bus_rdata)
   );

   assign step = cfg.use_tick ? tick_1us : 1'b1;

   wdt_counter #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(cfg.run), .step(step), .kick(kick),
      .reload(reload), .cnt_q(cnt), .fire_q(fire)
   );

   wdt_expiry u_exp (
      .clk(clk), .rst_n(rst_n), .fire(fire), .rst_on(cfg.rst_on),
      .irq_on(cfg.irq_on), .ext_on(cfg.ext_on), .boot_on(cfg.alt_boot),
      .stat_clr(stat_clr), .rst_req(wdt_rst_req), .ext_req(wdt_ext_req),
      .boot_req(wdt_alt_boot_req), .irq(wdt_irq), .stat_q(stat)
   );

   assign wdt_rst_scope = cfg.scope;

endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             kick,
   input logic             run,
   input logic             fire,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] reload,
   input logic [1:0]       stat
);

   assert_key_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (cnt == $past(reload)));

   assert_fire_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

   assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !kick) |=> (cnt == '0));

   assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !kick) |=> $stable(cnt));

   assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[0]) |-> $past(fire));

   assert_boot_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stat[1] |=> stat[1]);

endmodule

bind wdt_core wdt_core_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .kick(kick), .run(cfg.run), .fire(fire),
   .cnt(cnt), .reload(reload), .stat(stat)
);

// File: tb/wdt_core_test.sv
module wdt_core_test;

   localparam int unsigned RST_VAL = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_1us = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdt_irq, wdt_rst_req, wdt_ext_req, wdt_alt_boot_req;
   logic [1:0]  wdt_rst_scope;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wdt_core #(.RELOAD_RST(32'(RST_VAL)), .HAS_FAST_CLK(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req), .wdt_rst_scope(wdt_rst_scope),
      .wdt_ext_req(wdt_ext_req), .wdt_alt_boot_req(wdt_alt_boot_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // load a value while stopped, then start with the given configuration
   task automatic arm(input logic [31:0] val, input logic [31:0] cfg);
      wr(5'h0C, 32'h0);
      wr(5'h04, val);
      wr(5'h08, 32'h4755);
      wr(5'h0C, cfg);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(5'h00, d); check("R1 count", d, RST_VAL);
      rd(5'h0C, d); check("R1 cfg", d, 0);
      rd(5'h10, d); check("R1 status", d, 0);
      check("R1 outputs", {wdt_irq, wdt_rst_req, wdt_ext_req, wdt_alt_boot_req}, 0);
   endtask

   task automatic t_regs;
      logic [31:0] d;
      wr(5'h04, 32'h1234_5678);
      rd(5'h04, d); check("R2 reload readback", d, 32'h1234_5678);
      wr(5'h0C, 32'h0000_0060);
      rd(5'h0C, d); check("R2 cfg readback", d, 32'h60);
      rd(5'h08, d); check("R2 key reads zero", d, 0);
      check("R7 scope reserved", wdt_rst_scope, 2'b11);
      wr(5'h0C, 32'h20); check("R7 scope full chip", wdt_rst_scope, 2'b01);
      wr(5'h0C, 32'h40); check("R7 scope cpu", wdt_rst_scope, 2'b10);
      wr(5'h0C, 32'h00); check("R7 scope soc", wdt_rst_scope, 2'b00);
   endtask

   task automatic t_key;
      logic [31:0] d;
      wr(5'h04, 32'd100);
      wr(5'h08, 32'h0000_1234);
      rd(5'h00, d); check("R3 wrong key ignored", d, RST_VAL);
      wr(5'h08, 32'h0001_4755);
      rd(5'h00, d); check("R3 upper bits ignored", d, RST_VAL);
      wr(5'h08, 32'h0000_4755);
      rd(5'h00, d); check("R3 key loads", d, 100);
   endtask

   task automatic t_expire;
      logic [31:0] d;
      int k;
      logic ext_seen, boot_seen;
      arm(32'd5, 32'h8F);
      k = 0;
      ext_seen = 1'b0; boot_seen = 1'b0;
      while (k < 50) begin
         k++;
         cycles(1);
         if (wdt_rst_req) begin
            ext_seen = wdt_ext_req; boot_seen = wdt_alt_boot_req;
            break;
         end
      end
      check("R5 expiry step", k, 5);
      check("R5 ext with reset", ext_seen, 1);
      check("R5 boot with reset", boot_seen, 1);
      cycles(1);
      check("R5 one cycle", {wdt_rst_req, wdt_ext_req, wdt_alt_boot_req}, 0);
      rd(5'h10, d); check("R8 R9 status", d, 3);
      check("R10 irq high", wdt_irq, 1);
      k = 0;
      for (int i = 0; i < 20; i++) begin
         cycles(1);
         if (wdt_rst_req) k++;
      end
      check("R5 no re-expiry", k, 0);
      rd(5'h00, d); check("R5 holds zero", d, 0);
   endtask

   task automatic t_status;
      logic [31:0] d;
      wr(5'h10, 32'h1);
      rd(5'h10, d); check("R8 w1c clears flag", d, 2);
      check("R10 irq drops", wdt_irq, 0);
      wr(5'h10, 32'h2);
      rd(5'h10, d); check("R9 boot flag sticky", d, 2);
   endtask

   task automatic t_irq_mask;
      logic [31:0] d;
      arm(32'd2, 32'h01);
      cycles(5);
      rd(5'h10, d); check("R8 flag set again", d[0], 1);
      check("R10 irq masked", wdt_irq, 0);
      wr(5'h0C, 32'h05);
      check("R10 irq unmasked", wdt_irq, 1);
      wr(5'h10, 32'h1);
      check("R10 irq after clear", wdt_irq, 0);
   endtask

   task automatic t_freeze;
      logic [31:0] c1, d;
      arm(32'd50, 32'h01);
      cycles(10);
      wr(5'h0C, 32'h00);
      rd(5'h00, c1);
      cycles(20);
      rd(5'h00, d); check("R6 frozen", d, c1);
      rd(5'h04, d); check("R6 reload kept", d, 50);
      wr(5'h0C, 32'h01);
      cycles(3);
      rd(5'h00, d); check("R6 resumes", d, c1 - 3);
   endtask

   task automatic t_tick;
      logic [31:0] d;
      arm(32'd3, 32'h13);
      cycles(20);
      rd(5'h00, d); check("R4 no tick no step", d, 3);
      for (int i = 0; i < 3; i++) begin
         check("R4 not yet expired", wdt_rst_req, 0);
         @(negedge clk); tick_1us = 1'b1;
         @(posedge clk);
         @(negedge clk); tick_1us = 1'b0;
         if (i < 2) begin
            rd(5'h00, d); check("R4 tick step", d, 32'(2 - i));
         end
      end
      check("R4 expiry on third tick", wdt_rst_req, 1);
   endtask

   task automatic t_zero;
      arm(32'd0, 32'h03);
      check("R5 zero load not yet", wdt_rst_req, 0);
      cycles(1);
      check("R5 zero load first step", wdt_rst_req, 1);
   endtask

   task automatic t_priority;
      logic [31:0] v0, d;
      arm(32'd20, 32'h01);
      cycles(5);
      rd(5'h00, v0);
      wr(5'h08, 32'h0000_4756);
      rd(5'h00, d); check("R3 bad key while running", d, v0 - 2);
      wr(5'h08, 32'h0000_4755);
      rd(5'h00, d); check("R11 key beats step", d, 20);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_key();
      t_expire();
      t_status();
      t_irq_mask();
      t_freeze();
      t_tick();
      t_zero();
      t_priority();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule